// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block watches four external interrupt inputs and decides, line by line, whether each one has fired. Every line has its own trigger mode: active-high level, active-low level, rising edge, falling edge or any edge. All control and status sit in a single 32-bit register on a plain bus. The bus has a write strobe, write data and read data that is always valid. Software clears latched events by writing ones to a clear field.

Each input first passes through a two-flop synchronizer. Edges are then found by comparing the synchronized value with a copy delayed by one cycle. The block drives one request per line, which is the latched status gated by that line's enable. It also drives the OR of those four requests.

A parameter chooses how the six per-line fields are packed. The narrow packing spaces the fields four bits apart. The wide packing spaces them five bits apart. Each field's offset is a multiple of the spacing, and the line index is added to it.

Top module: `xirq_trigger_ctrl`

## Requirements
- R1: While reset is asserted, every enable and status bit is 0 and every line is in level mode with polarity 0, which is active-low. Any-edge is 0 and req is 0.
- R2: With spacing S (4 by default, 5 when WIDE_PACK=1), line x uses the following read/write bits: polarity at x, status at S+x, clear at 2S+x, enable at 3S+x, any-edge at 4S+x and level at 5S+x. Every other bit reads 0.
- R3: With the level bit set, status equals (synchronized input == polarity). A clear has no lasting effect while the input is active.
- R4: With level=0 and any-edge=0, polarity 1 latches status on a rising input and polarity 0 latches status on a falling input. The opposite transition leaves status unchanged.
- R5: With level=0 and any-edge=1, both rising and falling transitions latch status.
- R6: Writing 1 to a line's clear bit removes its latched edge status, and several lines can be cleared in one write. Writing 0 to a clear bit leaves status unchanged. Clear bits always read 0.
- R7: Status bits are read-only: writing ones to the status field sets nothing.
- R8: req[x] is high exactly when the status of line x and its enable are both 1. Clearing the enable blocks req but keeps status. req_any is the OR of req.
- R9: An input change driven between clock edges shows up in status after the third rising edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 4 | External interrupt lines, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| req | output | 4 | Per-line masked interrupt request |
| req_any | output | 1 | OR of all requests |

## Verification
The bench drives an input between clock edges. Status follows after exactly three rising edges: two in the synchronizer and one in the status register. R9 checks that edge count directly. Every other input-driven check waits five falling edges before it samples, so the result has settled. A register write takes effect at the next rising edge, so a write followed by a wait of two falling edges shows its effect on a clear or an enable. A narrow-packing instance and a wide-packing instance run side by side on the same stimulus. Each has its own write data, and both are compared against the expectation the bench computes for the current mode.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
    localparam int XIRQ_LINES = 4;

    typedef struct packed {
        logic [XIRQ_LINES-1:0] pol;
        logic [XIRQ_LINES-1:0] en;
        logic [XIRQ_LINES-1:0] any;
        logic [XIRQ_LINES-1:0] lvl;
    } xirq_cfg_t;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] dly;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1  = d_in;
        st_d.s2  = st_q.s1;
        st_d.dly = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur  = st_q.s2;
    assign prev = st_q.dly;
endmodule

// File: rtl/xirq_line_detect.sv
module xirq_line_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic cur,
    input  logic prev,
    input  logic pol,
    input  logic any,
    input  logic lvl,
    input  logic clr,
    output logic stat
);
    logic stat_d, stat_q;
    logic hit;

    always_comb begin
        if (any)      hit = cur ^ prev;
        else if (pol) hit = cur & ~prev;
        else          hit = ~cur & prev;
        if (lvl) stat_d = (cur == pol);
        else     stat_d = hit | (stat_q & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= 1'b0;
        else        stat_q <= stat_d;
    end

    assign stat = stat_q;

    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        lvl |=> (stat_q == $past(cur == pol)));                       // R3
    AST_RISE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && !any && pol && cur && !prev) |=> stat_q);            // R4
    AST_ANY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && any && (cur != prev)) |=> stat_q);                   // R5
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && clr && (cur == prev)) |=> !stat_q);                  // R6
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && !clr && (cur == prev)) |=> $stable(stat_q));         // R7
endmodule

// File: rtl/xirq_trigger_ctrl.sv
module xirq_trigger_ctrl #(
    parameter int LINES     = xirq_pkg::XIRQ_LINES,
    parameter int DATA_W    = 32,
    parameter bit WIDE_PACK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_in,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [LINES-1:0]  req,
    output logic              req_any
);
    import xirq_pkg::*;

    localparam int STRIDE   = WIDE_PACK ? 5 : 4;
    localparam int OFF_POL  = 0;
    localparam int OFF_STAT = STRIDE;
    localparam int OFF_CLR  = 2 * STRIDE;
    localparam int OFF_EN   = 3 * STRIDE;
    localparam int OFF_ANY  = 4 * STRIDE;
    localparam int OFF_LVL  = 5 * STRIDE;

    xirq_cfg_t        cfg_d, cfg_q;
    logic [LINES-1:0] clr_pulse;
    logic [LINES-1:0] cur, prev, stat;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    always_comb begin
        cfg_d     = cfg_q;
        clr_pulse = '0;
        if (wr_en) begin
            for (int i = 0; i < LINES; i++) begin
                cfg_d.pol[i] = wr_data[OFF_POL + i];
                cfg_d.en[i]  = wr_data[OFF_EN + i];
                cfg_d.any[i] = wr_data[OFF_ANY + i];
                cfg_d.lvl[i] = wr_data[OFF_LVL + i];
                clr_pulse[i] = wr_data[OFF_CLR + i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.pol <= '0;
            cfg_q.en  <= '0;
            cfg_q.any <= '0;
            cfg_q.lvl <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    xirq_sync #(.W(LINES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (irq_in),
        .cur  (cur),
        .prev (prev)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_line
        xirq_line_detect u_det (
            .clk  (clk),
            .rst_n(rst_n),
            .cur  (cur[g]),
            .prev (prev[g]),
            .pol  (cfg_q.pol[g]),
            .any  (cfg_q.any[g]),
            .lvl  (cfg_q.lvl[g]),
            .clr  (clr_pulse[g]),
            .stat (stat[g])
        );

        AST_DISABLE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_data[OFF_EN + g]) |=> !req[g]);             // R8
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < LINES; i++) begin
            rd_data[OFF_POL + i]  = cfg_q.pol[i];
            rd_data[OFF_STAT + i] = stat[i];
            rd_data[OFF_EN + i]   = cfg_q.en[i];
            rd_data[OFF_ANY + i]  = cfg_q.any[i];
            rd_data[OFF_LVL + i]  = cfg_q.lvl[i];
        end
    end

    assign req     = stat & cfg_q.en;
    assign req_any = |req;

    AST_ANY_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
        req_any == (req != '0));                                      // R8
endmodule

// File: tb/xirq_trigger_ctrl_bench.sv
module xirq_trigger_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_in = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wd4 = '0, wd5 = '0;
    logic [31:0] rd4, rd5;
    logic [3:0]  req4, req5;
    logic        any4, any5;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    xirq_trigger_ctrl u_xirq_trigger_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .wr_data(wd4), .rd_data(rd4), .req(req4), .req_any(any4));

    xirq_trigger_ctrl #(.WIDE_PACK(1'b1)) u_xirq_trigger_ctrl_wide (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .wr_data(wd5), .rd_data(rd5), .req(req5), .req_any(any5));

    function automatic logic [31:0] pack(int s, logic [3:0] pol, logic [3:0] en,
                                         logic [3:0] any, logic [3:0] lvl,
                                         logic [3:0] clr, logic [3:0] st);
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++) begin
            r[i]       = pol[i];
            r[s + i]   = st[i];
            r[2*s + i] = clr[i];
            r[3*s + i] = en[i];
            r[4*s + i] = any[i];
            r[5*s + i] = lvl[i];
        end
        return r;
    endfunction

    function automatic logic [3:0] stat_of(logic [31:0] rd, int s);
        return 4'((rd >> s) & 32'hF);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // mode: 0 level-high, 1 level-low, 2 rising, 3 falling, 4 any-edge
    logic [3:0] m_pol, m_any, m_lvl, m_en;

    task automatic set_mode(int m, logic [3:0] en);
        m_pol = (m == 0 || m == 2) ? 4'hF : 4'h0;
        m_any = (m == 4) ? 4'hF : 4'h0;
        m_lvl = (m <= 1) ? 4'hF : 4'h0;
        m_en  = en;
    endtask

    task automatic wr(logic [3:0] clr, logic [3:0] st);
        @(negedge clk);
        wr_en = 1'b1;
        wd4 = pack(4, m_pol, m_en, m_any, m_lvl, clr, st);
        wd5 = pack(5, m_pol, m_en, m_any, m_lvl, clr, st);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_stat(string tag, logic [3:0] exp);
        logic [3:0] r = exp & m_en;
        check({tag, " stat narrow"}, 32'(stat_of(rd4, 4)), 32'(exp));
        check({tag, " stat wide"},   32'(stat_of(rd5, 5)), 32'(exp));
        check({tag, " req narrow"},  32'(req4), 32'(r));
        check({tag, " req wide"},    32'(req5), 32'(r));
        check({tag, " req_any"},     32'({any4, any5}), 32'({|r, |r}));
    endtask

    initial begin
        logic [3:0] oth;
        logic [3:0] ea, eb, ec, ed;
        // R1: reset state
        waitn(3);
        set_mode(1, 4'h0);
        check("R1 reset narrow", rd4, pack(4, 4'h0, 4'h0, 4'h0, 4'hF, 4'h0, 4'h0));
        check("R1 reset wide",   rd5, pack(5, 4'h0, 4'h0, 4'h0, 4'hF, 4'h0, 4'h0));
        check("R1 reset req",    32'({req4, req5, any4, any5}), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        waitn(5);

        // R3 R4 R5: sweep every mode on every line
        for (int m = 0; m < 5; m++) begin
            for (int ln = 0; ln < 4; ln++) begin
                set_mode(m, 4'(1 << ln));
                wr(4'h0, 4'h0);
                waitn(5);
                wr(4'hF, 4'h0);
                waitn(2);
                oth = (m == 1) ? 4'hF : 4'h0;
                case (m)
                    0: begin ea = 0; eb = 1; ec = 1; ed = 0; end
                    1: begin ea = 1; eb = 0; ec = 0; ed = 1; end
                    2: begin ea = 0; eb = 1; ec = 0; ed = 0; end
                    3: begin ea = 0; eb = 0; ec = 0; ed = 1; end
                    default: begin ea = 0; eb = 1; ec = 0; ed = 1; end
                endcase
                check_stat($sformatf("R3 R4 R5 m%0d l%0d idle", m, ln),
                           (oth & ~4'(1 << ln)) | (ea[0] ? 4'(1 << ln) : 4'h0));
                irq_in[ln] = 1'b1;
                waitn(5);
                check_stat($sformatf("R3 R4 R5 m%0d l%0d rise", m, ln),
                           (oth & ~4'(1 << ln)) | (eb[0] ? 4'(1 << ln) : 4'h0));
                wr(4'(1 << ln), 4'h0);
                waitn(2);
                check_stat($sformatf("R3 R6 m%0d l%0d clear", m, ln),
                           (oth & ~4'(1 << ln)) | (ec[0] ? 4'(1 << ln) : 4'h0));
                irq_in[ln] = 1'b0;
                waitn(5);
                check_stat($sformatf("R3 R4 R5 m%0d l%0d fall", m, ln),
                           (oth & ~4'(1 << ln)) | (ed[0] ? 4'(1 << ln) : 4'h0));
            end
        end

        // R9: latency on line 0 in rising mode
        set_mode(2, 4'h1);
        wr(4'hF, 4'h0);
        waitn(2);
        irq_in[0] = 1'b1;
        waitn(2);
        check_stat("R9 after two edges", 4'h0);
        waitn(1);
        check_stat("R9 after three edges", 4'h1);

        // R6: clear-all, R7: status read-only, write of 0 keeps status
        irq_in = 4'hF;
        waitn(5);
        set_mode(2, 4'hF);
        wr(4'h0, 4'h0);
        waitn(2);
        check_stat("R6 zero clear keeps", 4'hF);
        wr(4'hF, 4'h0);
        waitn(2);
        check_stat("R6 clear all", 4'h0);
        wr(4'h0, 4'hF);
        waitn(2);
        check_stat("R7 status read-only", 4'h0);
        irq_in = 4'h0;
        waitn(5);
        check_stat("R4 falling ignored in rising mode", 4'h0);

        // R8: enable gates req, status survives
        irq_in[2] = 1'b1;
        waitn(5);
        check_stat("R8 enabled", 4'h4);
        set_mode(2, 4'h0);
        wr(4'h0, 4'h0);
        waitn(2);
        check_stat("R8 masked keeps status", 4'h4);
        set_mode(2, 4'h4);
        wr(4'h0, 4'h0);
        waitn(2);
        check_stat("R8 re-enabled", 4'h4);
        irq_in = 4'h0;
        waitn(5);

        // R2: field layout read-back, clear bits read 0
        m_pol = 4'b1010; m_en = 4'b0000; m_any = 4'b0011; m_lvl = 4'b1100;
        wr(4'hF, 4'h0);
        waitn(2);
        check("R2 layout narrow", rd4 & ~32'h0000_00F0,
              pack(4, 4'b1010, 4'b0000, 4'b0011, 4'b1100, 4'h0, 4'h0));
        check("R2 layout wide", rd5 & ~32'h0000_01E0,
              pack(5, 4'b1010, 4'b0000, 4'b0011, 4'b1100, 4'h0, 4'h0));
        m_en = 4'b0110;
        wr(4'h0, 4'h0);
        waitn(2);
        check("R2 enable narrow", rd4 & ~32'h0000_00F0,
              pack(4, 4'b1010, 4'b0110, 4'b0011, 4'b1100, 4'h0, 4'h0));
        check("R2 enable wide", rd5 & ~32'h0000_01E0,
              pack(5, 4'b1010, 4'b0110, 4'b0011, 4'b1100, 4'h0, 4'h0));

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule